// File: doc/BRIEF.md
# Bidirectional FIFO Pair with Loopback

This block holds two synchronous FIFOs that face opposite directions across one clock. The forward FIFO takes words written on Port A and hands them to a far-side consumer. The return FIFO takes words written by a far-side producer and hands them to Port A readers. Port A accesses are qualified by an active-low chip select, an active-high enable, a direction bit and a mailbox select. The word presented on Port A comes either from a held output register (standard read mode) or straight from the return FIFO's head (first-word-fall-through mode).

A loopback mode drains the return FIFO into the forward FIFO, one word per cycle, with no Port A access. In the echo variant Port A keeps driving, so the looped words can be seen on the bus. In the quiet variant Port A is released. A four-state controller tracks the Port A mode. ST_IDLE means Port A is released and not in loop. ST_DRIVE means Port A is selected in the read direction and drives its data. ST_ECHO is loopback with Port A driven, and ST_QUIET is loopback with Port A released. Every state moves to its successor on each clock edge using the same rule:
- loop request with echo set goes to ST_ECHO;
- loop request with echo clear goes to ST_QUIET;
- no loop request, chip select low and direction = read goes to ST_DRIVE;
- anything else goes to ST_IDLE.

Top module: `dual_fifo_loop`

## Requirements
- R1: A synchronous reset (rst high) empties both FIFOs, so both empty flags read 1 and both full flags read 0. It also clears the held Port A word to zero and puts the controller in ST_IDLE with pa_oe = 0.
- R2: A Port A access (pa_cs_n = 0, pa_en = 1, pa_mbox = 0) with pa_wr = 1, taken in ST_IDLE or ST_DRIVE, pushes pa_din into the forward FIFO. far_dout shows the oldest unread forward word, and far_rd = 1 pops it, so words leave in write order.
- R3: In standard mode (fwft = 0), a Port A access with pa_wr = 0 pops the return FIFO head into the held register. pa_dout shows the held register and changes only when a pop occurs.
- R4: In first-word-fall-through mode (fwft = 1), pa_dout shows the return FIFO head while that FIFO is not empty. When it is empty, pa_dout shows the held register, which is the last word popped.
- R5: A push into a full FIFO or a pop from an empty FIFO is ignored and leaves that FIFO's contents and flags unchanged. Full and empty are registered and match the occupancy after each edge.
- R6: With pa_cs_n = 1, pa_en = 0 or pa_mbox = 1, Port A neither pushes nor pops either FIFO.
- R7: The controller state follows the transition rule above, one cycle after its inputs. pa_oe is 1 exactly in ST_DRIVE and ST_ECHO.
- R8: In ST_ECHO or ST_QUIET, every edge at which the return FIFO is not empty and the forward FIFO is not full moves one word. The word written into the forward FIFO equals pa_dout in the cycle before that edge. In standard mode this is the previously presented held word, and the popped head becomes the new held word. In FWFT mode it is the head itself.
- R9: During echo loopback pa_oe = 1. During quiet loopback pa_oe = 0.
- R10: In either loop state, Port A accesses neither write the forward FIFO nor read the return FIFO.
- R11: Far-side pushes (far_wr) and pops (far_rd) proceed during loopback. Each FIFO's flags track only that FIFO's own occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port A and far-side clock |
| rst | input | 1 | Synchronous reset, active high |
| fwft | input | 1 | 1 = first-word-fall-through read mode, 0 = standard |
| pa_cs_n | input | 1 | Port A chip select, active low |
| pa_en | input | 1 | Port A enable, active high |
| pa_wr | input | 1 | Port A direction: 1 write forward FIFO, 0 read return FIFO |
| pa_mbox | input | 1 | Mailbox select; when 1 the access is not a FIFO access |
| pa_din | input | W | Port A write data |
| pa_dout | output | W | Port A presented word |
| pa_oe | output | 1 | Port A output enable (0 = released) |
| loop_en | input | 1 | Loopback request |
| loop_echo | input | 1 | Loopback variant: 1 echo on Port A, 0 quiet |
| far_rd | input | 1 | Far-side pop of the forward FIFO |
| far_dout | output | W | Forward FIFO head word |
| far_wr | input | 1 | Far-side push into the return FIFO |
| far_din | input | W | Far-side write data |
| f1_full | output | 1 | Forward FIFO full |
| f1_empty | output | 1 | Forward FIFO empty |
| f2_full | output | 1 | Return FIFO full |
| f2_empty | output | 1 | Return FIFO empty |

## Verification
The first looped word in standard mode is the main target. A design that forwards the unread head instead of the held word skips one word and shows up as a mismatch on far_dout. The bench drives loops with the forward FIFO full, with the return FIFO empty, and with far-side traffic running at the same time. A transfer that ignores either flag would overwrite a full FIFO or copy a stale word. The bench also attempts Port A writes during both loop variants and sweeps the chip select, enable and mailbox combinations. Leaking one of them would add stray forward words, and a wrong output-enable decode would drive the bus in quiet loop or release it in echo loop.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_ECHO  = 2'd2,
        ST_QUIET = 2'd3
    } pa_state_e;
endpackage

// File: rtl/dfl_fifo.sv
module dfl_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          do_push, do_pop;

    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rptr];

    always_comb begin
        unique case ({do_push, do_pop})
            2'b10:   cnt_nxt = cnt + CW'(1);
            2'b01:   cnt_nxt = cnt - CW'(1);
            default: cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt   <= '0;
            full  <= 1'b0;
            empty <= 1'b1;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
            cnt   <= cnt_nxt;
            full  <= (cnt_nxt == CW'(DEPTH));
            empty <= (cnt_nxt == '0);
        end
    end
endmodule

// File: rtl/dfl_pa_ctrl.sv
module dfl_pa_ctrl
    import dfl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      en,
    input  logic      wr,
    input  logic      mbox,
    input  logic      loop_en,
    input  logic      loop_echo,
    output pa_state_e state,
    output logic      oe,
    output logic      wr_req,
    output logic      rd_req,
    output logic      loop_act
);
    pa_state_e state_nxt;
    logic      access;

    assign access = ~cs_n & en & ~mbox;

    always_comb begin
        if (loop_en)
            state_nxt = loop_echo ? ST_ECHO : ST_QUIET;
        else if (~cs_n & ~wr)
            state_nxt = ST_DRIVE;
        else
            state_nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        oe       = 1'b0;
        wr_req   = 1'b0;
        rd_req   = 1'b0;
        loop_act = 1'b0;
        unique case (state)
            ST_IDLE: begin
                wr_req = access & wr;
                rd_req = access & ~wr;
            end
            ST_DRIVE: begin
                oe     = 1'b1;
                wr_req = access & wr;
                rd_req = access & ~wr;
            end
            ST_ECHO: begin
                oe       = 1'b1;
                loop_act = 1'b1;
            end
            ST_QUIET: begin
                loop_act = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dual_fifo_loop.sv
module dual_fifo_loop
    import dfl_pkg::*;
#(
    parameter int W     = 36,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fwft,
    input  logic         pa_cs_n,
    input  logic         pa_en,
    input  logic         pa_wr,
    input  logic         pa_mbox,
    input  logic [W-1:0] pa_din,
    output logic [W-1:0] pa_dout,
    output logic         pa_oe,
    input  logic         loop_en,
    input  logic         loop_echo,
    input  logic         far_rd,
    output logic [W-1:0] far_dout,
    input  logic         far_wr,
    input  logic [W-1:0] far_din,
    output logic         f1_full,
    output logic         f1_empty,
    output logic         f2_full,
    output logic         f2_empty
);
    pa_state_e    pa_state;
    logic         wr_req, rd_req, loop_act;
    logic         loop_xfer;
    logic         f1_push, f1_pop, f2_push, f2_pop;
    logic [W-1:0] f1_din, f2_head, hold_q, loop_word;

    dfl_pa_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (pa_cs_n),
        .en        (pa_en),
        .wr        (pa_wr),
        .mbox      (pa_mbox),
        .loop_en   (loop_en),
        .loop_echo (loop_echo),
        .state     (pa_state),
        .oe        (pa_oe),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .loop_act  (loop_act)
    );

    assign loop_xfer = loop_act & ~f2_empty & ~f1_full;
    assign loop_word = fwft ? f2_head : hold_q;

    assign f1_push = loop_xfer | (wr_req & ~f1_full);
    assign f1_din  = loop_xfer ? loop_word : pa_din;
    assign f1_pop  = far_rd & ~f1_empty;
    assign f2_push = far_wr & ~f2_full;
    assign f2_pop  = loop_xfer | (rd_req & ~f2_empty);

    dfl_fifo #(.W(W), .DEPTH(DEPTH)) u_fwd (
        .clk   (clk),
        .rst   (rst),
        .push  (f1_push),
        .pop   (f1_pop),
        .din   (f1_din),
        .head  (far_dout),
        .full  (f1_full),
        .empty (f1_empty)
    );

    dfl_fifo #(.W(W), .DEPTH(DEPTH)) u_ret (
        .clk   (clk),
        .rst   (rst),
        .push  (f2_push),
        .pop   (f2_pop),
        .din   (far_din),
        .head  (f2_head),
        .full  (f2_full),
        .empty (f2_empty)
    );

    always_ff @(posedge clk) begin
        if (rst)         hold_q <= '0;
        else if (f2_pop) hold_q <= f2_head;
    end

    assign pa_dout = (fwft & ~f2_empty) ? f2_head : hold_q;
endmodule

// File: rtl/dfl_checker.sv
module dfl_checker
    import dfl_pkg::*;
#(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst,
    input logic         fwft,
    input logic         loop_en,
    input logic         loop_echo,
    input logic         far_rd,
    input logic         far_wr,
    input logic         pa_oe,
    input logic [W-1:0] pa_dout,
    input logic         f1_full,
    input logic         f1_empty,
    input logic         f2_empty,
    input logic         f2_pop,
    input pa_state_e    pa_state
);
    p_full_stays_r5: assert property (@(posedge clk) disable iff (rst)
        (f1_full && !far_rd) |=> f1_full);

    p_empty_stays_r5: assert property (@(posedge clk) disable iff (rst)
        (f2_empty && !far_wr) |=> f2_empty);

    p_echo_drives_r9: assert property (@(posedge clk) disable iff (rst)
        (loop_en && loop_echo) |=> pa_oe);

    p_quiet_released_r9: assert property (@(posedge clk) disable iff (rst)
        (loop_en && !loop_echo) |=> !pa_oe);

    p_loop_moves_r8: assert property (@(posedge clk) disable iff (rst)
        ((pa_state == ST_ECHO || pa_state == ST_QUIET) && !f2_empty && !f1_full)
        |=> !f1_empty);

    p_quiet_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        (pa_state == ST_QUIET && f2_empty && f1_empty) |=> f1_empty);

    p_std_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!fwft && !f2_pop) |=> (fwft || $stable(pa_dout)));
endmodule

bind dual_fifo_loop dfl_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fwft      (fwft),
    .loop_en   (loop_en),
    .loop_echo (loop_echo),
    .far_rd    (far_rd),
    .far_wr    (far_wr),
    .pa_oe     (pa_oe),
    .pa_dout   (pa_dout),
    .f1_full   (f1_full),
    .f1_empty  (f1_empty),
    .f2_empty  (f2_empty),
    .f2_pop    (f2_pop),
    .pa_state  (pa_state)
);

// File: tb/dual_fifo_loop_bench.sv
module dual_fifo_loop_bench;
    localparam int W = 36;
    localparam int D = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fwft = 1'b0;
    logic pa_cs_n = 1'b1, pa_en = 1'b0, pa_wr = 1'b0, pa_mbox = 1'b0;
    logic [W-1:0] pa_din = '0, far_din = '0;
    logic loop_en = 1'b0, loop_echo = 1'b0, far_rd = 1'b0, far_wr = 1'b0;
    logic [W-1:0] pa_dout, far_dout;
    logic pa_oe, f1_full, f1_empty, f2_full, f2_empty;

    always #10 clk = ~clk;

    dual_fifo_loop #(.W(W), .DEPTH(D)) u_dual_fifo_loop (
        .clk(clk), .rst(rst), .fwft(fwft),
        .pa_cs_n(pa_cs_n), .pa_en(pa_en), .pa_wr(pa_wr), .pa_mbox(pa_mbox),
        .pa_din(pa_din), .pa_dout(pa_dout), .pa_oe(pa_oe),
        .loop_en(loop_en), .loop_echo(loop_echo),
        .far_rd(far_rd), .far_dout(far_dout), .far_wr(far_wr), .far_din(far_din),
        .f1_full(f1_full), .f1_empty(f1_empty), .f2_full(f2_full), .f2_empty(f2_empty)
    );

    // behavioural reference
    logic [W-1:0] q1[$];
    logic [W-1:0] q2[$];
    logic [W-1:0] hold = '0;
    int ms = 0;           // 0 idle, 1 drive, 2 echo, 3 quiet
    int n1, n2;
    bit acc, lp, pop1, push1, pop2, push2;
    logic [W-1:0] wd, d1;

    always @(posedge clk) begin
        if (rst) begin
            q1.delete(); q2.delete(); hold = '0; ms = 0;
        end else begin
            n1 = q1.size(); n2 = q2.size();
            acc   = !pa_cs_n && pa_en && !pa_mbox && ms < 2;
            lp    = ms >= 2 && n2 > 0 && n1 < D;
            wd    = (fwft && n2 > 0) ? q2[0] : hold;
            pop1  = far_rd && n1 > 0;
            push1 = lp || (acc && pa_wr && n1 < D);
            d1    = lp ? wd : pa_din;
            pop2  = lp || (acc && !pa_wr && n2 > 0);
            push2 = far_wr && n2 < D;
            if (pop1)  void'(q1.pop_front());
            if (push1) q1.push_back(d1);
            if (pop2)  hold = q2.pop_front();
            if (push2) q2.push_back(far_din);
            if (loop_en)                ms = loop_echo ? 2 : 3;
            else if (!pa_cs_n && !pa_wr) ms = 1;
            else                        ms = 0;
        end
    end

    int compared = 0, mismatched = 0;
    string tag = "R1";
    bit done = 0;

    task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        logic [W-1:0] exp_dout;
        exp_dout = (fwft && q2.size() > 0) ? q2[0] : hold;
        chk("f1_empty", W'(f1_empty), W'(q1.size() == 0));
        chk("f1_full",  W'(f1_full),  W'(q1.size() == D));
        chk("f2_empty", W'(f2_empty), W'(q2.size() == 0));
        chk("f2_full",  W'(f2_full),  W'(q2.size() == D));
        chk("pa_oe",    W'(pa_oe),    W'(ms == 1 || ms == 2));
        chk("pa_dout",  pa_dout, exp_dout);
        if (q1.size() > 0) chk("far_dout", far_dout, q1[0]);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic pa_idle();
        pa_cs_n = 1'b1; pa_en = 1'b0; pa_wr = 1'b0; pa_mbox = 1'b0;
    endtask

    function automatic logic [W-1:0] rnd();
        return W'({$urandom(), $urandom()});
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(7));
        // R1: reset state
        tag = "R1";
        repeat (3) step();
        rst = 1'b0;
        step();

        // R2: Port A writes into forward FIFO, far side reads in order
        tag = "R2";
        for (int i = 0; i < 6; i++) begin
            pa_cs_n = 0; pa_en = 1; pa_wr = 1; pa_din = W'(100 + i);
            step();
        end
        pa_idle(); far_rd = 1;
        repeat (3) step();
        far_rd = 0;

        // R3: standard reads, held word stays put between reads
        tag = "R3";
        for (int i = 0; i < 5; i++) begin
            far_wr = 1; far_din = W'(200 + i); step();
        end
        far_wr = 0;
        pa_cs_n = 0; pa_en = 1; pa_wr = 0;
        repeat (2) step();
        pa_en = 0;
        repeat (3) step();

        // R4: fall-through reads, then reading past empty (R5)
        tag = "R4";
        fwft = 1; step();
        pa_en = 1;
        repeat (4) step();
        tag = "R5";
        repeat (2) step();
        pa_idle(); step();

        // R5: overfill forward FIFO
        for (int i = 0; i < 20; i++) begin
            pa_cs_n = 0; pa_en = 1; pa_wr = 1; pa_din = W'(300 + i);
            step();
        end
        pa_idle(); far_rd = 1;
        repeat (8) step();
        far_rd = 0;

        // R6: unqualified accesses
        tag = "R6";
        far_wr = 1; far_din = W'(400); step(); far_wr = 0;
        for (int k = 0; k < 2; k++) begin
            pa_wr = k[0]; pa_din = W'(500 + k);
            pa_cs_n = 1; pa_en = 1; pa_mbox = 0; repeat (2) step();
            pa_cs_n = 0; pa_en = 0; pa_mbox = 0; repeat (2) step();
            pa_cs_n = 0; pa_en = 1; pa_mbox = 1; repeat (2) step();
        end
        pa_idle(); step();

        // R7: controller transitions
        tag = "R7";
        pa_cs_n = 0; pa_wr = 0; step(); step();
        pa_wr = 1; step();
        loop_en = 1; loop_echo = 1; step();
        loop_echo = 0; step();
        loop_en = 0; pa_wr = 0; step();
        pa_idle(); step();

        // R8 / R9: echo loopback in standard mode, with Port A writes tried (R10)
        fwft = 0; tag = "R8";
        for (int i = 0; i < 8; i++) begin
            far_wr = 1; far_din = W'(600 + i); step();
        end
        far_wr = 0;
        loop_en = 1; loop_echo = 1;
        pa_cs_n = 0; pa_en = 1; pa_wr = 1; pa_din = W'(999);
        tag = "R9";
        repeat (12) step();
        // R10: quiet loopback ignores Port A writes and reads
        tag = "R10";
        loop_echo = 0;
        for (int i = 0; i < 6; i++) begin
            far_wr = 1; far_din = W'(700 + i); pa_wr = i[0]; step();
        end
        far_wr = 0;
        repeat (6) step();
        // loop blocked with forward FIFO full
        tag = "R8";
        for (int i = 0; i < 10; i++) begin
            far_wr = 1; far_din = W'(750 + i); step();
        end
        far_wr = 0; step();
        far_rd = 1; repeat (4) step(); far_rd = 0;
        loop_en = 0; pa_idle(); far_rd = 1;
        repeat (20) step();
        far_rd = 0;

        // R8 in fall-through mode
        fwft = 1;
        for (int i = 0; i < 5; i++) begin
            far_wr = 1; far_din = W'(800 + i); step();
        end
        far_wr = 0;
        loop_en = 1; loop_echo = 1; repeat (3) step();
        loop_echo = 0; repeat (4) step();
        loop_en = 0; far_rd = 1; repeat (10) step(); far_rd = 0;

        // R11: random traffic across all modes with far side active
        tag = "R11";
        for (int c = 0; c < 4000; c++) begin
            if (c % 8 == 0) begin
                loop_en = ($urandom() % 3) == 0;
                loop_echo = $urandom() % 2;
                fwft = ($urandom() % 4) == 0 ? ~fwft : fwft;
            end
            pa_cs_n = ($urandom() % 5) == 0;
            pa_en   = ($urandom() % 4) != 0;
            pa_wr   = $urandom() % 2;
            pa_mbox = ($urandom() % 8) == 0;
            pa_din  = rnd();
            far_wr  = ($urandom() % 3) != 0;
            far_rd  = ($urandom() % 3) != 0;
            far_din = rnd();
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule